// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block produces the byte a byte-wide NOR flash puts on its data bus while an internal program or erase is running. A controlling state machine tells it when an operation starts: which kind (byte program, sector erase or chip erase), which address it targets, the byte being written and the byte the array held before. It also passes on suspend events, second-confirm (30h) writes and reset events. For each bus read strobe the block either returns the array data presented to it or a status byte. The status byte is built from a data-polling bit, two toggle bits, a timeout flag and an erase-window flag.

An internal pulse counter advances on each `tick` while an operation runs and is not suspended. A program finishes after `PROG_PULSES` ticks and an erase after `ERASE_PULSES` ticks. A program that tries to turn a 0 bit back into a 1 never finishes. Once `LIMIT_PULSES` ticks have passed it raises the timeout flag and stays busy until a reset event. The address is split into seven sectors: a 16K boot sector, two 8K parameter sectors, a 32K sector and three 64K sectors. Parameter `TOP_BOOT` puts the boot and parameter sectors at the high end of the map instead of the low end.

Top module: `fstat_gen`

## Requirements
- R1: After `rst_n` is released, `busy` is 0 and `dout` is 0x00. While no operation is busy, a read strobe loads `dout` with `arr_data` on the clock edge at which the strobe is sampled.
- R2: The sector of an address comes from address bits 17:13, one unit per 8K. With `TOP_BOOT`=0 the units map to sectors as follows: 0-1 boot, 2 first parameter, 3 second parameter, 4-7 the 32K sector, then 8-15, 16-23 and 24-31 the 64K sectors. With `TOP_BOOT`=1 the order is mirrored: 0-7, 8-15 and 16-23 are the 64K sectors, 24-27 the 32K sector, 28 and 29 the parameter sectors, and 30-31 boot.
- R3: Status bit 6 inverts on every read strobe while an operation runs and is not suspended. The `op_start` that launches an operation clears it to 0. Once the operation ends, reads return array data.
- R4: Status byte layout: bit 7 is the polling bit, bit 6 the toggle bit, bit 5 timeout, bit 3 erase window and bit 2 the erase toggle bit; bits 4, 1 and 0 are 0. During a program, bit 7 is the complement of bit 7 of `op_wdata`. During an erase it is 0. `op_kind` encodes 1 as program, 2 as sector erase and 3 as chip erase, and 0 is ignored.
- R5: A program ends (`busy` falls) on the `PROG_PULSES`-th tick and an erase on the `ERASE_PULSES`-th tick.
- R6: A program with `op_wdata & ~op_old` nonzero never ends. Bit 5 reads 0 up to tick `LIMIT_PULSES`-1 and 1 from tick `LIMIT_PULSES` on. Bit 6 keeps toggling and bit 7 keeps its polling value.
- R7: Only `rst_evt` ends a hung operation. It clears `busy`, the flags, both toggle bits and `dout`, and later reads return array data.
- R8: Bit 3 is 1 for every status read of a sector erase from its start, and 0 during program and chip erase.
- R9: `resume30` while a sector erase runs has no effect, so the erase still ends on tick `ERASE_PULSES`. While the erase is suspended, `resume30` resumes it.
- R10: Bit 2 inverts on a read strobe during a chip erase at any address. During a running sector erase it inverts only when the read address lies in the target sector. During a program it holds.
- R11: `suspend_evt` during a running sector erase freezes the pulse count. A read outside the target sector then returns `arr_data`. A read inside it returns bit 7 = 1, bit 6 unchanged, bit 3 = 1 and bit 2 inverted.
- R12: `op_start` while an operation is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rd_strobe | input | 1 | One-cycle bus read event |
| rd_addr | input | 18 | Read address |
| arr_data | input | 8 | Array contents at `rd_addr` |
| op_start | input | 1 | Launch an embedded operation |
| op_kind | input | 2 | 1 program, 2 sector erase, 3 chip erase |
| op_addr | input | 18 | Target address of the operation |
| op_wdata | input | 8 | Byte being programmed |
| op_old | input | 8 | Byte previously stored at `op_addr` |
| tick | input | 1 | Internal pulse tick |
| suspend_evt | input | 1 | Erase suspend request |
| resume30 | input | 1 | 30h confirm write during an operation |
| rst_evt | input | 1 | Reset event, returns to array read |
| dout | output | 8 | Read response byte |
| busy | output | 1 | An embedded operation is in progress |

## Verification
The assertions assume that the stimulus presents `rd_strobe`, `op_start`, `suspend_evt`, `resume30` and `rst_evt` as single-cycle pulses and never asserts two of them in the same cycle. They also assume that `arr_data` is valid in the cycle of the strobe. The bench drives every event in its own cycle, away from the clock edge. It starts each scenario with a reset event, so the toggle state it predicts begins at 0, and it never ticks during a strobe. Pulse counts are checked one tick before and at the completion or limit tick.

// File: rtl/fstat_pkg.sv
package fstat_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PROG = 2'd1,
        OP_SECT = 2'd2,
        OP_CHIP = 2'd3
    } op_kind_e;

    localparam int BIT_POLL = 7;
    localparam int BIT_TOG  = 6;
    localparam int BIT_TMO  = 5;
    localparam int BIT_WIN  = 3;
    localparam int BIT_ETOG = 2;

    localparam int SECT_W   = 3;
    localparam int UNIT_W   = 5;

endpackage

// File: rtl/fstat_sector_map.sv
module fstat_sector_map
    import fstat_pkg::*;
#(
    parameter int AW       = 18,
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic [AW-1:0]     addr,
    output logic [SECT_W-1:0] sector
);

    logic [UNIT_W-1:0] unit;
    logic              unused_lo;

    assign unit      = addr[AW-1 -: UNIT_W];
    assign unused_lo = ^addr[AW-UNIT_W-1:0];

    function automatic logic [SECT_W-1:0] low_boot_idx(input logic [UNIT_W-1:0] u);
        logic [SECT_W-1:0] s;
        if (u < 5'd2)       s = 3'd0;
        else if (u == 5'd2) s = 3'd1;
        else if (u == 5'd3) s = 3'd2;
        else if (u < 5'd8)  s = 3'd3;
        else if (u < 5'd16) s = 3'd4;
        else if (u < 5'd24) s = 3'd5;
        else                s = 3'd6;
        return s;
    endfunction

    generate
        if (TOP_BOOT) begin : g_top
            always_comb sector = 3'd6 - low_boot_idx(~unit);
        end else begin : g_bottom
            always_comb sector = low_boot_idx(unit);
        end
    endgenerate

endmodule

// File: rtl/fstat_pulse_ctr.sv
module fstat_pulse_ctr
    import fstat_pkg::*;
#(
    parameter int PROG_PULSES  = 4,
    parameter int ERASE_PULSES = 10,
    parameter int LIMIT_PULSES = 16,
    localparam int CW = $clog2(LIMIT_PULSES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    input  op_kind_e      kind,
    input  logic          viol,
    output logic          done,
    output logic          limit_hit,
    output logic [CW-1:0] count
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        logic fin_prog, fin_erase;
        fin_prog  = (kind == OP_PROG) && !viol && (cnt_q == CW'(PROG_PULSES - 1));
        fin_erase = (kind != OP_PROG) && (kind != OP_NONE) && (cnt_q == CW'(ERASE_PULSES - 1));
        done      = run && (fin_prog || fin_erase);
        limit_hit = run && (cnt_q == CW'(LIMIT_PULSES - 1));
        cnt_d     = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (run && (cnt_q < CW'(LIMIT_PULSES)))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

endmodule

// File: rtl/fstat_read_mux.sv
module fstat_read_mux
    import fstat_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          busy,
    input  logic          susp,
    input  op_kind_e      kind,
    input  logic          in_sect,
    input  logic          wbit7,
    input  logic          tmo,
    input  logic          tog6_q,
    input  logic          tog2_q,
    input  logic [DW-1:0] arr_data,
    output logic          tog6_n,
    output logic          tog2_n,
    output logic [DW-1:0] resp
);

    logic status_mode;

    assign status_mode = busy && (!susp || in_sect);

    always_comb begin
        tog6_n = tog6_q;
        tog2_n = tog2_q;
        resp   = arr_data;
        if (status_mode) begin
            resp = '0;
            if (susp) begin
                tog2_n         = !tog2_q;
                resp[BIT_POLL] = 1'b1;
                resp[BIT_WIN]  = 1'b1;
            end else begin
                tog6_n = !tog6_q;
                if ((kind == OP_CHIP) || ((kind == OP_SECT) && in_sect))
                    tog2_n = !tog2_q;
                resp[BIT_POLL] = (kind == OP_PROG) ? !wbit7 : 1'b0;
                resp[BIT_WIN]  = (kind == OP_SECT);
            end
            resp[BIT_TOG]  = tog6_n;
            resp[BIT_TMO]  = tmo;
            resp[BIT_ETOG] = tog2_n;
        end
    end

endmodule

// File: rtl/fstat_gen.sv
module fstat_gen
    import fstat_pkg::*;
#(
    parameter int AW           = 18,
    parameter int DW           = 8,
    parameter bit TOP_BOOT     = 1'b0,
    parameter int PROG_PULSES  = 4,
    parameter int ERASE_PULSES = 10,
    parameter int LIMIT_PULSES = 16,
    localparam int CW = $clog2(LIMIT_PULSES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_strobe,
    input  logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] arr_data,
    input  logic          op_start,
    input  logic [1:0]    op_kind,
    input  logic [AW-1:0] op_addr,
    input  logic [DW-1:0] op_wdata,
    input  logic [DW-1:0] op_old,
    input  logic          tick,
    input  logic          suspend_evt,
    input  logic          resume30,
    input  logic          rst_evt,
    output logic [DW-1:0] dout,
    output logic          busy
);

    typedef struct packed {
        logic              busy;
        logic              susp;
        op_kind_e          kind;
        logic [SECT_W-1:0] sect;
        logic              wbit7;
        logic              viol;
        logic              tmo;
        logic              tog6;
        logic              tog2;
        logic [DW-1:0]     dout;
    } st_t;

    st_t st_d, st_q;

    logic [SECT_W-1:0] rd_sect, op_sect;
    logic              tog6_n, tog2_n;
    logic [DW-1:0]     resp;
    logic              start_ok;
    logic              ctr_clear, ctr_run, ctr_done, ctr_limit;
    logic [CW-1:0]     ctr_count;
    op_kind_e          kind_in;

    assign kind_in   = op_kind_e'(op_kind);
    assign start_ok  = !rst_evt && op_start && !st_q.busy && (kind_in != OP_NONE);
    assign ctr_clear = rst_evt || start_ok;
    assign ctr_run   = !rst_evt && tick && st_q.busy && !st_q.susp;

    fstat_sector_map #(.AW(AW), .TOP_BOOT(TOP_BOOT)) u_rd_map (
        .addr   (rd_addr),
        .sector (rd_sect)
    );

    fstat_sector_map #(.AW(AW), .TOP_BOOT(TOP_BOOT)) u_op_map (
        .addr   (op_addr),
        .sector (op_sect)
    );

    fstat_read_mux #(.DW(DW)) u_mux (
        .busy     (st_q.busy),
        .susp     (st_q.susp),
        .kind     (st_q.kind),
        .in_sect  (rd_sect == st_q.sect),
        .wbit7    (st_q.wbit7),
        .tmo      (st_q.tmo),
        .tog6_q   (st_q.tog6),
        .tog2_q   (st_q.tog2),
        .arr_data (arr_data),
        .tog6_n   (tog6_n),
        .tog2_n   (tog2_n),
        .resp     (resp)
    );

    fstat_pulse_ctr #(
        .PROG_PULSES  (PROG_PULSES),
        .ERASE_PULSES (ERASE_PULSES),
        .LIMIT_PULSES (LIMIT_PULSES)
    ) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (ctr_clear),
        .run       (ctr_run),
        .kind      (st_q.kind),
        .viol      (st_q.viol),
        .done      (ctr_done),
        .limit_hit (ctr_limit),
        .count     (ctr_count)
    );

    always_comb begin
        st_d = st_q;
        if (rst_evt) begin
            st_d = '0;
        end else begin
            if (rd_strobe) begin
                st_d.dout = resp;
                st_d.tog6 = tog6_n;
                st_d.tog2 = tog2_n;
            end
            if (start_ok) begin
                st_d.busy  = 1'b1;
                st_d.susp  = 1'b0;
                st_d.kind  = kind_in;
                st_d.sect  = op_sect;
                st_d.wbit7 = op_wdata[DW-1];
                st_d.viol  = (kind_in == OP_PROG) && (|(op_wdata & ~op_old));
                st_d.tmo   = 1'b0;
                st_d.tog6  = 1'b0;
                st_d.tog2  = 1'b0;
            end else if (st_q.busy) begin
                if (suspend_evt && !st_q.susp && (st_q.kind == OP_SECT))
                    st_d.susp = 1'b1;
                else if (resume30 && st_q.susp)
                    st_d.susp = 1'b0;
                if (ctr_limit)
                    st_d.tmo = 1'b1;
                if (ctr_done) begin
                    st_d.busy = 1'b0;
                    st_d.susp = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.dout;
    assign busy = st_q.busy;

endmodule

// File: rtl/fstat_gen_chk.sv
module fstat_gen_chk
    import fstat_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_strobe,
    input logic          rst_evt,
    input logic [DW-1:0] arr_data,
    input logic [DW-1:0] dout,
    input logic          busy,
    input logic          susp,
    input logic          viol,
    input logic          tmo,
    input logic          tog6,
    input op_kind_e      kind,
    input logic [CW-1:0] count
);

    p_idle_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe && !busy && !rst_evt |=> dout == $past(arr_data));

    p_tog_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe && busy && !susp && !rst_evt |=> dout[BIT_TOG] == !$past(tog6));

    p_erase_poll_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe && busy && !susp && (kind != OP_PROG) && !rst_evt |=> dout[BIT_POLL] == 1'b0);

    p_hang_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && viol && !rst_evt |=> busy);

    p_tmo_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && tmo && !rst_evt |=> tmo);

    p_reset_evt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_evt |=> !busy && (dout == '0));

    p_susp_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy && susp && !rst_evt |=> $stable(count));

endmodule

bind fstat_gen fstat_gen_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_strobe (rd_strobe),
    .rst_evt   (rst_evt),
    .arr_data  (arr_data),
    .dout      (dout),
    .busy      (busy),
    .susp      (st_q.susp),
    .viol      (st_q.viol),
    .tmo       (st_q.tmo),
    .tog6      (st_q.tog6),
    .kind      (st_q.kind),
    .count     (ctr_count)
);

// File: tb/fstat_gen_test.sv
`timescale 1ns/1ps
module fstat_gen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_strobe = 1'b0;
    logic [17:0] rd_addr = '0;
    logic [7:0]  arr_data = '0;
    logic        op_start = 1'b0;
    logic [1:0]  op_kind = '0;
    logic [17:0] op_addr = '0;
    logic [7:0]  op_wdata = '0;
    logic [7:0]  op_old = '0;
    logic        tick = 1'b0;
    logic        suspend_evt = 1'b0;
    logic        resume30 = 1'b0;
    logic        rst_evt = 1'b0;
    logic [7:0]  dout, dout_t;
    logic        busy, busy_t;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    fstat_gen #(.TOP_BOOT(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rd_addr(rd_addr),
        .arr_data(arr_data), .op_start(op_start), .op_kind(op_kind),
        .op_addr(op_addr), .op_wdata(op_wdata), .op_old(op_old), .tick(tick),
        .suspend_evt(suspend_evt), .resume30(resume30), .rst_evt(rst_evt),
        .dout(dout), .busy(busy)
    );

    fstat_gen #(.TOP_BOOT(1'b1)) uut_top (
        .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rd_addr(rd_addr),
        .arr_data(arr_data), .op_start(op_start), .op_kind(op_kind),
        .op_addr(op_addr), .op_wdata(op_wdata), .op_old(op_old), .tick(tick),
        .suspend_evt(suspend_evt), .resume30(resume30), .rst_evt(rst_evt),
        .dout(dout_t), .busy(busy_t)
    );

    function automatic logic [7:0] stat(input logic p7, input logic b6,
                                        input logic b5, input logic b3, input logic b2);
        return {p7, b6, b5, 1'b0, b3, b2, 2'b00};
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic read(input logic [17:0] a, input logic [7:0] arr,
                        output logic [7:0] r, output logic [7:0] rt);
        @(negedge clk);
        rd_strobe = 1'b1; rd_addr = a; arr_data = arr;
        @(negedge clk);
        rd_strobe = 1'b0;
        r = dout; rt = dout_t;
    endtask

    task automatic pulse_evt(input int which);
        @(negedge clk);
        case (which)
            0: rst_evt = 1'b1;
            1: suspend_evt = 1'b1;
            default: resume30 = 1'b1;
        endcase
        @(negedge clk);
        rst_evt = 1'b0; suspend_evt = 1'b0; resume30 = 1'b0;
    endtask

    task automatic start(input logic [1:0] k, input logic [17:0] a,
                         input logic [7:0] w, input logic [7:0] o);
        @(negedge clk);
        op_start = 1'b1; op_kind = k; op_addr = a; op_wdata = w; op_old = o;
        @(negedge clk);
        op_start = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic t_reset;
        logic [7:0] r, rt;
        check("R1 reset busy", {7'd0, busy}, 8'h00);
        check("R1 reset dout", dout, 8'h00);
        read(18'h01234, 8'hA5, r, rt);
        check("R1 idle pass", r, 8'hA5);
        read(18'h3FFFF, 8'h3C, r, rt);
        check("R1 idle pass 2", r, 8'h3C);
    endtask

    task automatic t_program;
        logic [7:0] r, rt;
        pulse_evt(0);
        start(2'd1, 18'h00100, 8'h80, 8'hFF);
        check("R12 busy after start", {7'd0, busy}, 8'h01);
        read(18'h00100, 8'h11, r, rt);
        check("R4 prog status first", r, stat(1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
        read(18'h00100, 8'h11, r, rt);
        check("R3 prog toggle second", r, stat(1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        start(2'd2, 18'h20000, 8'h00, 8'h00);
        read(18'h20000, 8'h11, r, rt);
        check("R12 start ignored", r, stat(1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
        ticks(3);
        check("R5 prog busy at tick 3", {7'd0, busy}, 8'h01);
        ticks(1);
        check("R5 prog done at tick 4", {7'd0, busy}, 8'h00);
        read(18'h00100, 8'h80, r, rt);
        check("R3 true data after done", r, 8'h80);
        read(18'h00100, 8'h80, r, rt);
        check("R4 no toggle after done", r, 8'h80);
    endtask

    task automatic t_hang;
        logic [7:0] r, rt;
        pulse_evt(0);
        start(2'd1, 18'h00200, 8'h01, 8'h00);
        ticks(15);
        read(18'h00200, 8'h00, r, rt);
        check("R6 no timeout at tick 15", r, stat(1'b1, 1'b1, 1'b0, 1'b0, 1'b0));
        ticks(1);
        read(18'h00200, 8'h00, r, rt);
        check("R6 timeout at tick 16", r, stat(1'b1, 1'b0, 1'b1, 1'b0, 1'b0));
        ticks(20);
        check("R6 still busy", {7'd0, busy}, 8'h01);
        read(18'h00200, 8'h00, r, rt);
        check("R6 toggling after timeout", r, stat(1'b1, 1'b1, 1'b1, 1'b0, 1'b0));
        pulse_evt(0);
        check("R7 busy cleared", {7'd0, busy}, 8'h00);
        check("R7 dout cleared", dout, 8'h00);
        read(18'h00200, 8'h42, r, rt);
        check("R7 array read after reset", r, 8'h42);
    endtask

    task automatic t_sector_erase;
        logic [7:0] r, rt;
        pulse_evt(0);
        start(2'd2, 18'h05000, 8'h00, 8'h00);
        read(18'h05800, 8'h99, r, rt);
        check("R8 R10 in-sector first", r, stat(1'b0, 1'b1, 1'b0, 1'b1, 1'b1));
        read(18'h05FFF, 8'h99, r, rt);
        check("R10 in-sector second", r, stat(1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
        read(18'h06000, 8'h99, r, rt);
        check("R2 R10 next sector holds", r, stat(1'b0, 1'b1, 1'b0, 1'b1, 1'b0));
        read(18'h03FFF, 8'h99, r, rt);
        check("R2 boot sector holds", r, stat(1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
        ticks(5);
        pulse_evt(2);
        ticks(4);
        check("R9 confirm ignored busy at 9", {7'd0, busy}, 8'h01);
        ticks(1);
        check("R5 R9 erase done at 10", {7'd0, busy}, 8'h00);
    endtask

    task automatic t_suspend;
        logic [7:0] r, rt;
        pulse_evt(0);
        start(2'd2, 18'h20000, 8'h00, 8'h00);
        ticks(3);
        pulse_evt(1);
        ticks(20);
        check("R11 frozen while suspended", {7'd0, busy}, 8'h01);
        read(18'h10000, 8'h5A, r, rt);
        check("R11 outside sector array", r, 8'h5A);
        read(18'h2ABCD, 8'h5A, r, rt);
        check("R11 inside sector status", r, stat(1'b1, 1'b0, 1'b0, 1'b1, 1'b1));
        pulse_evt(2);
        read(18'h2ABCD, 8'h5A, r, rt);
        check("R9 resumed status", r, stat(1'b0, 1'b1, 1'b0, 1'b1, 1'b0));
        ticks(6);
        check("R9 busy at 9 after resume", {7'd0, busy}, 8'h01);
        ticks(1);
        check("R9 done at 10 after resume", {7'd0, busy}, 8'h00);
    endtask

    task automatic t_chip_erase;
        logic [7:0] r, rt;
        pulse_evt(0);
        start(2'd3, 18'h00000, 8'h00, 8'h00);
        read(18'h00000, 8'h00, r, rt);
        check("R10 chip any addr 1", r, stat(1'b0, 1'b1, 1'b0, 1'b0, 1'b1));
        read(18'h3FFFF, 8'h00, r, rt);
        check("R8 R10 chip any addr 2", r, stat(1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
        read(18'h14000, 8'h00, r, rt);
        check("R10 chip any addr 3", r, stat(1'b0, 1'b1, 1'b0, 1'b0, 1'b1));
        ticks(10);
        check("R5 chip done", {7'd0, busy}, 8'h00);
    endtask

    task automatic t_top_layout;
        logic [7:0] r, rt;
        pulse_evt(0);
        start(2'd2, 18'h38000, 8'h00, 8'h00);
        read(18'h39FFF, 8'h00, r, rt);
        check("R2 top param in-sector", rt, stat(1'b0, 1'b1, 1'b0, 1'b1, 1'b1));
        read(18'h37FFF, 8'h00, r, rt);
        check("R2 top 32K outside", rt, stat(1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
        read(18'h3A000, 8'h00, r, rt);
        check("R2 top other param outside", rt, stat(1'b0, 1'b1, 1'b0, 1'b1, 1'b1));
        read(18'h38000, 8'h00, r, rt);
        check("R2 top in-sector again", rt, stat(1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
        pulse_evt(0);
        start(2'd2, 18'h3C000, 8'h00, 8'h00);
        read(18'h3FFFF, 8'h00, r, rt);
        check("R2 top boot in-sector", rt, stat(1'b0, 1'b1, 1'b0, 1'b1, 1'b1));
        read(18'h3BFFF, 8'h00, r, rt);
        check("R2 top boot outside", rt, stat(1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
        pulse_evt(0);
    endtask

    initial begin
        #700000;
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_hang();
        t_sector_erase();
        t_suspend();
        t_chip_erase();
        t_top_layout();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule